// File: doc/BRIEF.md
# Hardware-updatable register bank

This block is a small bank of control and status registers behind a simple word-addressed read/write port. One software control word holds an 8-bit bit-enable vector, an 8-bit protect vector and a few strobe bits. Five 8-bit data fields sit behind the control word. Each data field can be changed by hardware through a load strobe with a new value, a clear strobe or a set strobe. Each field is wired to its own sources and its own kind of qualification.

The first field takes its strobes from input pins. Only the bits named by the enable vector may change. The second field also takes its strobes from pins, but the protect vector freezes the bits it names. The third field is writable by software. Its enable, clear, set and load strobes all come from bits of the control word. The fourth field loads its pin value for as long as an active-low control bit is held at 0. The fifth field loads its pin value when a separate load pin is high.

A read request returns its data in the cycle after the request. Hardware updates are registered, so a read sees them from the cycle after the strobe.

Top module: `hwupd_regbank`

## Requirements
- R1: The control word is at byte offset 0x0. Its fields are: enable vector in bits [7:0] (reset 0xFF), protect vector in bits [15:8] (reset 0x00), clear bit 16, set bit 17 and load bit 18 (each reset 0), and active-low load bit 20 (reset 1). Bit 19 and bits 21 and up read as 0. After reset the word reads 0x1000FF.
- R2: The data fields are at offsets 0x4, 0x8, 0xC, 0x10 and 0x14. They reset to 0x11, 0x22, 0x33, 0x44 and 0x55, and they read back in bits [7:0] with the upper bits 0.
- R3: The field at 0x4 changes only through its load, clear and set pins, and only in bits where the enable vector is 1. Its other bits hold. Without a strobe the whole field holds. A software write to 0x4 has no effect.
- R4: In the field at 0x8, bits where the protect vector is 1 never change. The other bits follow its load, clear and set pins.
- R5: When several hardware updates act in one cycle, clear beats set and set beats load, on each qualified bit.
- R6: The field at 0xC is software read/write. Its hardware clear, set and load are control bits 16, 17 and 18. They are qualified by the enable vector, and the load value comes from a pin.
- R7: The field at 0x10 loads its pin value on every clock edge at which control bit 20 is 0.
- R8: The field at 0x14 loads its pin value only on a clock edge at which its load pin is high. Otherwise it holds.
- R9: A software write to the field at 0xC, 0x10 or 0x14 takes priority over a hardware update in the same cycle.
- R10: Read data is registered and valid in the cycle after the read request. It reads 0 after a cycle without a read request and after a read of an unmapped offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset; bits [1:0] are ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read request |
| a_we | input | 1 | Field 0x4 load strobe |
| a_next | input | 8 | Field 0x4 load value |
| a_clr | input | 1 | Field 0x4 clear strobe |
| a_set | input | 1 | Field 0x4 set strobe |
| b_we | input | 1 | Field 0x8 load strobe |
| b_next | input | 8 | Field 0x8 load value |
| b_clr | input | 1 | Field 0x8 clear strobe |
| b_set | input | 1 | Field 0x8 set strobe |
| c_next | input | 8 | Field 0xC load value |
| d_next | input | 8 | Field 0x10 load value |
| e_we | input | 1 | Field 0x14 load strobe |
| e_next | input | 8 | Field 0x14 load value |

## Verification
The bound assertions check, on every cycle, the properties that hold whatever the stimulus:
- bits of the 0x4 field outside the enable vector never move, and the field holds without a strobe;
- protected bits of the 0x8 field never move;
- a clear leaves every enabled bit at 0;
- the 0x14 field holds without a load or a write, and a software write to it lands as written;
- unmapped reads return 0.

The exact values after a load, clear or set need the bench's scenarios. So do the control-driven updates of the 0xC and 0x10 fields, reset values, the control-word layout and the rejection of writes to the read-only field.

// File: rtl/hwupd_pkg.sv
`timescale 1ns/1ps
package hwupd_pkg;
   localparam int FW           = 8;
   localparam int NFLD         = 5;
   localparam int CTL_EN_LSB   = 0;
   localparam int CTL_MASK_LSB = 8;
   localparam int CTL_CLR_BIT  = 16;
   localparam int CTL_SET_BIT  = 17;
   localparam int CTL_WE_BIT   = 18;
   localparam int CTL_WELN_BIT = 20;

   typedef struct packed {
      logic          wel_n;
      logic          we;
      logic          set;
      logic          clr;
      logic [FW-1:0] mask;
      logic [FW-1:0] en;
   } ctl_t;

   localparam ctl_t CTL_RST = '{wel_n: 1'b1, we: 1'b0, set: 1'b0, clr: 1'b0,
                                mask: '0, en: '1};
endpackage

// File: rtl/hwupd_ctrl.sv
`timescale 1ns/1ps
module hwupd_ctrl import hwupd_pkg::*; #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  ctl_t              wval,
   output ctl_t              ctl,
   output logic [DATA_W-1:0] rd_word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctl <= CTL_RST;
      else if (wr_en) ctl <= wval;
   end

   always_comb begin
      rd_word                       = '0;
      rd_word[CTL_EN_LSB +: FW]     = ctl.en;
      rd_word[CTL_MASK_LSB +: FW]   = ctl.mask;
      rd_word[CTL_CLR_BIT]          = ctl.clr;
      rd_word[CTL_SET_BIT]          = ctl.set;
      rd_word[CTL_WE_BIT]           = ctl.we;
      rd_word[CTL_WELN_BIT]         = ctl.wel_n;
   end
endmodule

// File: rtl/hwupd_field.sv
`timescale 1ns/1ps
module hwupd_field #(
   parameter int         W           = 8,
   parameter logic [W-1:0] RST       = '0,
   parameter bit         SW_WRITABLE = 1'b1,
   parameter bit         QUAL_INVERT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sw_we,
   input  logic [W-1:0] sw_wdata,
   input  logic         hw_we,
   input  logic [W-1:0] hw_next,
   input  logic         hw_clr,
   input  logic         hw_set,
   input  logic [W-1:0] qual,
   output logic [W-1:0] q
);
   logic [W-1:0] allow;
   logic [W-1:0] hw_val;
   logic         sw_take;

   generate
      if (QUAL_INVERT) begin : g_protect
         assign allow = ~qual;
      end else begin : g_enable
         assign allow = qual;
      end
   endgenerate

   assign sw_take = SW_WRITABLE ? sw_we : 1'b0;

   // later steps override earlier ones: load < set < clear
   always_comb begin
      hw_val = q;
      if (hw_we)  hw_val = (hw_val & ~allow) | (hw_next & allow);
      if (hw_set) hw_val = hw_val | allow;
      if (hw_clr) hw_val = hw_val & ~allow;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= RST;
      else if (sw_take) q <= sw_wdata;
      else              q <= hw_val;
   end
endmodule

// File: rtl/hwupd_rdport.sv
`timescale 1ns/1ps
module hwupd_rdport import hwupd_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     rd_en,
   input  logic [IDX_W-1:0]         word,
   input  logic [DATA_W-1:0]        ctl_word,
   input  logic [NFLD-1:0][FW-1:0]  fq,
   output logic [DATA_W-1:0]        rdata
);
   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      if (word == '0) sel = ctl_word;
      for (int i = 0; i < NFLD; i++) begin
         if (word == IDX_W'(i + 1)) sel = DATA_W'(fq[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= sel;
      else            rdata <= '0;
   end
endmodule

// File: rtl/hwupd_regbank.sv
`timescale 1ns/1ps
module hwupd_regbank import hwupd_pkg::*; #(
   parameter int          ADDR_W = 8,
   parameter int          DATA_W = 32,
   parameter logic [FW-1:0] RST_A = 8'h11,
   parameter logic [FW-1:0] RST_B = 8'h22,
   parameter logic [FW-1:0] RST_C = 8'h33,
   parameter logic [FW-1:0] RST_D = 8'h44,
   parameter logic [FW-1:0] RST_E = 8'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              a_we,
   input  logic [FW-1:0]     a_next,
   input  logic              a_clr,
   input  logic              a_set,
   input  logic              b_we,
   input  logic [FW-1:0]     b_next,
   input  logic              b_clr,
   input  logic              b_set,
   input  logic [FW-1:0]     c_next,
   input  logic [FW-1:0]     d_next,
   input  logic              e_we,
   input  logic [FW-1:0]     e_next
);
   localparam int IDX_W = ADDR_W - 2;

   generate
      if (DATA_W < CTL_WELN_BIT + 2) begin : g_bad_data_w
         $error("hwupd_regbank: DATA_W must be at least 22");
      end
      if (ADDR_W < 5) begin : g_bad_addr_w
         $error("hwupd_regbank: ADDR_W must be at least 5");
      end
   endgenerate

   logic [IDX_W-1:0] word;
   logic             wr_ctl, wr_c, wr_d, wr_e, rd_en;
   ctl_t             ctl, ctl_wval;
   logic [DATA_W-1:0] ctl_word;
   logic [FW-1:0]    q_a, q_b, q_c, q_d, q_e;
   logic             unused_bits;

   assign word   = bus_addr[ADDR_W-1:2];
   assign wr_ctl = bus_req & bus_wr & (word == IDX_W'(0));
   assign wr_c   = bus_req & bus_wr & (word == IDX_W'(3));
   assign wr_d   = bus_req & bus_wr & (word == IDX_W'(4));
   assign wr_e   = bus_req & bus_wr & (word == IDX_W'(5));
   assign rd_en  = bus_req & ~bus_wr;

   assign ctl_wval = '{wel_n: bus_wdata[CTL_WELN_BIT],
                       we:    bus_wdata[CTL_WE_BIT],
                       set:   bus_wdata[CTL_SET_BIT],
                       clr:   bus_wdata[CTL_CLR_BIT],
                       mask:  bus_wdata[CTL_MASK_LSB +: FW],
                       en:    bus_wdata[CTL_EN_LSB +: FW]};

   assign unused_bits = ^{bus_addr[1:0], bus_wdata[CTL_WELN_BIT-1],
                          bus_wdata[DATA_W-1:CTL_WELN_BIT+1]};

   hwupd_ctrl #(.DATA_W(DATA_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_ctl), .wval(ctl_wval),
      .ctl(ctl), .rd_word(ctl_word)
   );

   hwupd_field #(.W(FW), .RST(RST_A), .SW_WRITABLE(1'b0), .QUAL_INVERT(1'b0)) u_fld_a (
      .clk(clk), .rst_n(rst_n), .sw_we(1'b0), .sw_wdata('0),
      .hw_we(a_we), .hw_next(a_next), .hw_clr(a_clr), .hw_set(a_set),
      .qual(ctl.en), .q(q_a)
   );

   hwupd_field #(.W(FW), .RST(RST_B), .SW_WRITABLE(1'b0), .QUAL_INVERT(1'b1)) u_fld_b (
      .clk(clk), .rst_n(rst_n), .sw_we(1'b0), .sw_wdata('0),
      .hw_we(b_we), .hw_next(b_next), .hw_clr(b_clr), .hw_set(b_set),
      .qual(ctl.mask), .q(q_b)
   );

   hwupd_field #(.W(FW), .RST(RST_C), .SW_WRITABLE(1'b1), .QUAL_INVERT(1'b0)) u_fld_c (
      .clk(clk), .rst_n(rst_n), .sw_we(wr_c), .sw_wdata(bus_wdata[FW-1:0]),
      .hw_we(ctl.we), .hw_next(c_next), .hw_clr(ctl.clr), .hw_set(ctl.set),
      .qual(ctl.en), .q(q_c)
   );

   hwupd_field #(.W(FW), .RST(RST_D), .SW_WRITABLE(1'b1), .QUAL_INVERT(1'b0)) u_fld_d (
      .clk(clk), .rst_n(rst_n), .sw_we(wr_d), .sw_wdata(bus_wdata[FW-1:0]),
      .hw_we(~ctl.wel_n), .hw_next(d_next), .hw_clr(1'b0), .hw_set(1'b0),
      .qual('1), .q(q_d)
   );

   hwupd_field #(.W(FW), .RST(RST_E), .SW_WRITABLE(1'b1), .QUAL_INVERT(1'b0)) u_fld_e (
      .clk(clk), .rst_n(rst_n), .sw_we(wr_e), .sw_wdata(bus_wdata[FW-1:0]),
      .hw_we(e_we), .hw_next(e_next), .hw_clr(1'b0), .hw_set(1'b0),
      .qual('1), .q(q_e)
   );

   hwupd_rdport #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rdport (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .word(word), .ctl_word(ctl_word),
      .fq({q_e, q_d, q_c, q_b, q_a}), .rdata(bus_rdata)
   );
endmodule

// File: rtl/hwupd_regbank_chk.sv
`timescale 1ns/1ps
module hwupd_regbank_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_wr,
   input logic [ADDR_W-3:0] word,
   input logic [7:0]        wbyte,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              a_we,
   input logic              a_clr,
   input logic              a_set,
   input logic              e_we,
   input logic [7:0]        en,
   input logic [7:0]        mask,
   input logic [7:0]        q_a,
   input logic [7:0]        q_b,
   input logic [7:0]        q_e
);
   logic wr_e_hit;
   assign wr_e_hit = bus_req && bus_wr && (word == (ADDR_W-2)'(5));

   AST_A_ENABLED_BITS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_a ^ $past(q_a)) & ~$past(en)) == 8'h00);            // R3
   AST_A_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_we || a_clr || a_set) |=> $stable(q_a));                      // R3
   AST_B_PROTECTED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q_b ^ $past(q_b)) & $past(mask)) == 8'h00);           // R4
   AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      a_clr |=> (q_a & $past(en)) == 8'h00);                            // R5
   AST_E_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!e_we && !wr_e_hit) |=> $stable(q_e));                           // R8
   AST_SW_OVER_HW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_e_hit |=> q_e == $past(wbyte));                                // R9
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_wr && word > (ADDR_W-2)'(5)) |=> bus_rdata == '0); // R10
endmodule

bind hwupd_regbank hwupd_regbank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .word(word),
   .wbyte(bus_wdata[7:0]), .bus_rdata(bus_rdata), .a_we(a_we), .a_clr(a_clr),
   .a_set(a_set), .e_we(e_we), .en(ctl.en), .mask(ctl.mask),
   .q_a(q_a), .q_b(q_b), .q_e(q_e)
);

// File: tb/hwupd_regbank_tb_top.sv
`timescale 1ns/1ps
module hwupd_regbank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        a_we = 0, a_clr = 0, a_set = 0, b_we = 0, b_clr = 0, b_set = 0, e_we = 0;
   logic [7:0]  a_next = 0, b_next = 0, c_next = 0, d_next = 0, e_next = 0;

   int checks = 0;
   int fails  = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        chk_rd = 1'b0;

   always #10 clk = ~clk;

   hwupd_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .a_we(a_we), .a_next(a_next), .a_clr(a_clr), .a_set(a_set),
      .b_we(b_we), .b_next(b_next), .b_clr(b_clr), .b_set(b_set),
      .c_next(c_next), .d_next(d_next), .e_we(e_we), .e_next(e_next)
   );

   // monitor: a read accepted at a rising edge is compared at the next falling edge
   always @(posedge clk) chk_rd <= bus_req && !bus_wr;
   always @(negedge clk) begin
      if (chk_rd) begin
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL scoreboard empty got=%h exp=none", bus_rdata);
         end else begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               fails++;
               $display("FAIL %s got=%h exp=%h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic bus_write(input logic [7:0] addr, input logic [31:0] data);
      @(negedge clk);
      bus_req = 1; bus_wr = 1; bus_addr = addr; bus_wdata = data;
      @(negedge clk);
      bus_req = 0; bus_wr = 0;
   endtask

   task automatic bus_read(input logic [7:0] addr, input logic [31:0] exp, input string tag);
      @(negedge clk);
      exp_q.push_back(exp); tag_q.push_back(tag);
      bus_req = 1; bus_wr = 0; bus_addr = addr;
      @(negedge clk);
      bus_req = 0;
   endtask

   task automatic pulse_a(input logic we, input logic [7:0] nx, input logic clr, input logic set);
      @(negedge clk);
      a_we = we; a_next = nx; a_clr = clr; a_set = set;
      @(negedge clk);
      a_we = 0; a_clr = 0; a_set = 0;
   endtask

   task automatic pulse_b(input logic we, input logic [7:0] nx, input logic clr, input logic set);
      @(negedge clk);
      b_we = we; b_next = nx; b_clr = clr; b_set = set;
      @(negedge clk);
      b_we = 0; b_clr = 0; b_set = 0;
   endtask

   task automatic finish_run();
      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard leftover got=%0d exp=0", exp_q.size());
      end
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      checks++;
      if (bus_rdata !== 32'h0) begin
         fails++;
         $display("FAIL R10 idle rdata got=%h exp=%h", bus_rdata, 32'h0);
      end
      bus_read(8'h00, 32'h0010_00FF, "R1 control reset");
      bus_read(8'h04, 32'h11, "R2 reset 0x4");
      bus_read(8'h08, 32'h22, "R2 reset 0x8");
      bus_read(8'h0C, 32'h33, "R2 reset 0xC");
      bus_read(8'h10, 32'h44, "R2 reset 0x10");
      bus_read(8'h14, 32'h55, "R2 reset 0x14");

      // field 0x4 with enable 0xF0 (active-low load bit kept at 1)
      bus_write(8'h00, 32'h0010_00F0);
      bus_read(8'h00, 32'h0010_00F0, "R1 control readback");
      pulse_a(1, 8'hAB, 0, 0);
      bus_read(8'h04, 32'hA1, "R3 load enabled bits");
      pulse_a(0, 8'h00, 1, 0);
      bus_read(8'h04, 32'h01, "R3 clear enabled bits");
      pulse_a(0, 8'h00, 0, 1);
      bus_read(8'h04, 32'hF1, "R3 set enabled bits");
      pulse_a(1, 8'h5C, 1, 1);
      bus_read(8'h04, 32'h01, "R5 clear beats set and load");
      pulse_a(1, 8'h00, 0, 1);
      bus_read(8'h04, 32'hF1, "R5 set beats load");
      bus_write(8'h04, 32'h77);
      bus_read(8'h04, 32'hF1, "R3 software write ignored");

      // field 0x8 with protect 0xF0
      bus_write(8'h00, 32'h0010_F000);
      pulse_b(1, 8'hAB, 0, 0);
      bus_read(8'h08, 32'h2B, "R4 load unprotected bits");
      pulse_b(0, 8'h00, 1, 0);
      bus_read(8'h08, 32'h20, "R4 clear unprotected bits");
      pulse_b(0, 8'h00, 0, 1);
      bus_read(8'h08, 32'h2F, "R4 set unprotected bits");

      // field 0xC driven by control bits
      bus_write(8'h00, 32'h0011_00F0);
      bus_write(8'h00, 32'h0010_0000);
      bus_read(8'h0C, 32'h03, "R6 control clear");
      bus_write(8'h00, 32'h0012_000F);
      bus_write(8'h00, 32'h0010_0000);
      bus_read(8'h0C, 32'h0F, "R6 control set");
      c_next = 8'hAA;
      bus_write(8'h00, 32'h0014_000F);
      bus_write(8'h00, 32'h0010_0000);
      bus_read(8'h0C, 32'h0A, "R6 control load");
      bus_write(8'h0C, 32'h5A);
      bus_read(8'h0C, 32'h5A, "R6 software write");

      // field 0x10 active-low load
      d_next = 8'hBB;
      bus_write(8'h00, 32'h0000_0000);
      bus_write(8'h00, 32'h0010_0000);
      bus_read(8'h10, 32'hBB, "R7 active-low load");
      d_next = 8'hCC;
      bus_read(8'h10, 32'hBB, "R7 hold while bit high");
      bus_write(8'h00, 32'h0000_0000);
      bus_write(8'h00, 32'h0010_0000);
      bus_read(8'h10, 32'hCC, "R7 second load");

      // field 0x14 separate load pin
      e_next = 8'h54;
      bus_read(8'h14, 32'h55, "R8 value ignored without load");
      @(negedge clk); e_next = 8'h56; e_we = 1;
      @(negedge clk); e_we = 0; e_next = 8'h00;
      bus_read(8'h14, 32'h56, "R8 load");

      // software write beats same-cycle hardware load
      @(negedge clk);
      e_we = 1; e_next = 8'h66;
      bus_req = 1; bus_wr = 1; bus_addr = 8'h14; bus_wdata = 32'h3C;
      @(negedge clk);
      e_we = 0; bus_req = 0; bus_wr = 0;
      bus_read(8'h14, 32'h3C, "R9 software wins on 0x14");

      // unmapped reads
      bus_read(8'h18, 32'h0, "R10 unmapped 0x18");
      bus_read(8'hFC, 32'h0, "R10 unmapped 0xFC");

      // reserved control bits and all-strobes precedence on 0xC
      bus_write(8'h00, 32'hFFFF_FFFF);
      bus_read(8'h00, 32'h0017_FFFF, "R1 reserved bits read 0");
      bus_read(8'h0C, 32'h00, "R5 clear beats set and load on 0xC");
      bus_read(8'h10, 32'hCC, "R7 hold with bit high");
      finish_run();
   end
endmodule